// File: doc/BRIEF.md
# Sprite-Zero Hit and Vertical-Blank Status Detector

This block sits beside a tile-based pixel pipeline and owns the frame position. A free-running dot counter walks 341 dots per scanline and 262 scanlines per frame. Lines 0 to 239 are visible, line 240 is idle, lines 241 to 260 form vertical blank, and line 261 is the pre-render line. The block publishes the current dot and line so that the pipeline can present the matching pixels on the same cycle. From those pixels it detects the first frame position where an opaque background pixel overlaps an opaque pixel of sprite slot zero, and latches a sticky hit flag. It also raises a vertical-blank flag and an NMI request at the first dot of vertical blank.

Each cycle the pipeline offers one background index and one sprite-zero index for the dot shown on `dot_col`/`scan_line`. `spr0_valid` qualifies the sprite index, and a low valid means the sprite pixel is transparent. The pixel stream has no ready signal and never sees back-pressure: the dot clock cannot stall, so every offered pixel is consumed in its own cycle. A processor reads the status byte by pulsing `rd_stb` for one cycle. The byte returned in that cycle shows the flags as they stood before that dot. The read clears the vertical-blank flag and leaves the hit flag set.

Top module: `sprite_zero_status`

## Requirements
- R1: After reset `dot_col` and `scan_line` are 0. `dot_col` counts 0..340 and then wraps while `scan_line` advances by one. After line 261 dot 340 the position returns to line 0 dot 0.
- R2: The hit flag (status bit 6) sets in the cycle after a dot where the background index and the sprite index are each non-zero, tested separately, with `spr0_valid` high. Background 1 with sprite 2 hits. A zero background index, or a low `spr0_valid`, gives no hit.
- R3: A dot at column 255 never sets the hit flag, even with both pixels opaque.
- R4: No hit is taken while `bg_on` or `spr_on` is low.
- R5: In columns 0..7 no hit is taken when `bg_left_hide` or `spr_left_hide` is high. From column 8 upward the hide bits have no effect.
- R6: Hits are taken only on lines 0..239 and columns 0..254. The idle line and dots 256..340 never hit.
- R7: Once set, the hit flag stays set until the end-of-blank clear. Further pixels and status reads do not change it.
- R8: The vertical-blank flag (status bit 7) reads 1 from the cycle after the counter shows line 241 dot 0.
- R9: When `nmi_en` is high, `nmi_req` is high for exactly the one cycle after line 241 dot 0. When `nmi_en` is low, `nmi_req` stays low.
- R10: A cycle with `rd_stb` high shows the status byte as it was before that dot. The vertical-blank flag then reads 0 from the next cycle. The start of vertical blank wins over a read in the same dot.
- R11: Both flags read 0 from the cycle after line 261 dot 0, which is exactly 20 lines (6820 dots) after vertical blank starts.
- R12: Status bits 5..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bg_pix | input | 2 | Background palette index for the current dot |
| spr0_pix | input | 2 | Sprite-slot-zero palette index for the current dot |
| spr0_valid | input | 1 | Qualifies `spr0_pix`; low means transparent |
| bg_on | input | 1 | Background rendering enabled |
| spr_on | input | 1 | Sprite rendering enabled |
| bg_left_hide | input | 1 | Background hidden in columns 0..7 |
| spr_left_hide | input | 1 | Sprites hidden in columns 0..7 |
| nmi_en | input | 1 | Allow the NMI request at the start of vertical blank |
| rd_stb | input | 1 | One-cycle status read strobe |
| dot_col | output | 9 | Current dot within the line |
| scan_line | output | 9 | Current line within the frame |
| status_byte | output | 8 | Bit 7 vertical blank, bit 6 sprite-zero hit, others zero |
| nmi_req | output | 1 | One-cycle NMI request |

## Verification
A counter that slips by even one dot shows at once on `dot_col`/`scan_line`. It also moves the rise of status bit 7 and the pulse on `nmi_req` by the same amount, so both are checked at the exact dot. A wrongly qualified hit appears on bit 6 one cycle after the offending dot and then persists for the rest of the frame. For that reason every suppression case runs in a frame before any legal hit, and it is judged by the byte in the next cycle. A clear that fires late or not at all leaves bit 6 or bit 7 visible past line 261 dot 0, and that dot is checked on both sides.

// File: rtl/sz_pkg.sv
package sz_pkg;
  localparam int unsigned PIX_W        = 2;
  localparam int unsigned STAT_W       = 8;
  localparam int unsigned STAT_VBL_BIT = 7;
  localparam int unsigned STAT_HIT_BIT = 6;

  typedef logic [PIX_W-1:0] pix_idx_t;

  typedef struct packed {
    logic bg_on;
    logic spr_on;
    logic bg_left_hide;
    logic spr_left_hide;
  } render_ctl_t;
endpackage

// File: rtl/sz_frame_timer.sv
module sz_frame_timer #(
  parameter int unsigned DOTS_PER_LINE = 341,
  parameter int unsigned VIS_LINES     = 240,
  parameter int unsigned VBL_LINES     = 20,
  parameter int unsigned TOTAL_LINES   = VIS_LINES + VBL_LINES + 2,
  parameter int unsigned COL_W         = $clog2(DOTS_PER_LINE),
  parameter int unsigned LINE_W        = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [COL_W-1:0]  col_o,
  output logic [LINE_W-1:0] line_o,
  output logic              visible_line_o,
  output logic              vbl_start_o,
  output logic              vbl_stop_o
);
  localparam int unsigned VBL_START = VIS_LINES + 1;
  localparam int unsigned VBL_STOP  = VBL_START + VBL_LINES;
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(DOTS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);

  logic [COL_W-1:0]  col_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (col_q == LAST_COL) begin
      col_q  <= '0;
      line_q <= (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  assign col_o          = col_q;
  assign line_o         = line_q;
  assign visible_line_o = (line_q < LINE_W'(VIS_LINES));
  assign vbl_start_o    = (line_q == LINE_W'(VBL_START)) && (col_q == '0);
  assign vbl_stop_o     = (line_q == LINE_W'(VBL_STOP)) && (col_q == '0);

  // R1: dot wraps after the last dot of a line
  assert_col_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q == LAST_COL) |=> (col_q == '0));
  // R1: line advances by one at a line end that is not the frame end
  assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q == LAST_COL && line_q != LAST_LINE) |=> (line_q == $past(line_q) + 1'b1));
  // R1: line holds within a line
  assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q != LAST_COL) |=> $stable(line_q));
  // R1: frame end returns to line 0
  assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q == LAST_COL && line_q == LAST_LINE) |=> (line_q == '0));
endmodule

// File: rtl/sz_hit_qualify.sv
module sz_hit_qualify
  import sz_pkg::*;
#(
  parameter int unsigned COL_W     = 9,
  parameter int unsigned VIS_COLS  = 256,
  parameter int unsigned CLIP_COLS = 8
) (
  input  logic [COL_W-1:0] col_i,
  input  logic             visible_line_i,
  input  pix_idx_t         bg_pix_i,
  input  pix_idx_t         spr_pix_i,
  input  logic             spr_valid_i,
  input  render_ctl_t      ctl_i,
  output logic             hit_evt_o
);
  logic bg_opaque, spr_opaque, col_in_area, col_is_last, in_clip, layers_on;

  // Opacity of each layer is judged on its own index, never on a combination
  assign bg_opaque   = |bg_pix_i;
  assign spr_opaque  = spr_valid_i && (|spr_pix_i);
  assign col_in_area = (col_i < COL_W'(VIS_COLS));
  assign col_is_last = (col_i == COL_W'(VIS_COLS - 1));
  assign layers_on   = ctl_i.bg_on && ctl_i.spr_on;

  generate
    if (CLIP_COLS > 0) begin : g_clip
      assign in_clip = (col_i < COL_W'(CLIP_COLS)) &&
                       (ctl_i.bg_left_hide || ctl_i.spr_left_hide);
    end else begin : g_no_clip
      assign in_clip = 1'b0;
    end
  endgenerate

  assign hit_evt_o = visible_line_i && col_in_area && !col_is_last && !in_clip &&
                     layers_on && bg_opaque && spr_opaque;
endmodule

// File: rtl/sz_status_regs.sv
module sz_status_regs
  import sz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_evt_i,
  input  logic              vbl_start_i,
  input  logic              vbl_stop_i,
  input  logic              rd_stb_i,
  input  logic              nmi_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              nmi_o
);
  logic vbl_q, hit_q, nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbl_q <= 1'b0;
      hit_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      if (vbl_start_i)     vbl_q <= 1'b1;
      else if (vbl_stop_i) vbl_q <= 1'b0;
      else if (rd_stb_i)   vbl_q <= 1'b0;

      if (vbl_stop_i)     hit_q <= 1'b0;
      else if (hit_evt_i) hit_q <= 1'b1;

      nmi_q <= vbl_start_i && nmi_en_i;
    end
  end

  always_comb begin
    status_o               = '0;
    status_o[STAT_VBL_BIT] = vbl_q;
    status_o[STAT_HIT_BIT] = hit_q;
  end

  assign nmi_o = nmi_q;

  // R7: hit stays until the end-of-blank clear
  assert_hit_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !vbl_stop_i) |=> hit_q);
  // R11: both flags are low after the end-of-blank dot
  assert_flags_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_stop_i |=> (!vbl_q && !hit_q));
  // R9: NMI request lasts a single cycle
  assert_nmi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |=> !nmi_q);
  // R8: vertical-blank flag rises only from the start dot
  assert_vbl_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbl_q && !vbl_start_i) |=> !vbl_q);
  // R10: a read clears the vertical-blank flag unless blank starts on that dot
  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !vbl_start_i) |=> !vbl_q);
endmodule

// File: rtl/sprite_zero_status.sv
module sprite_zero_status
  import sz_pkg::*;
#(
  parameter int unsigned DOTS_PER_LINE = 341,
  parameter int unsigned VIS_LINES     = 240,
  parameter int unsigned VBL_LINES     = 20,
  parameter int unsigned VIS_COLS      = 256,
  parameter int unsigned CLIP_COLS     = 8,
  localparam int unsigned TOTAL_LINES  = VIS_LINES + VBL_LINES + 2,
  localparam int unsigned COL_W        = $clog2(DOTS_PER_LINE),
  localparam int unsigned LINE_W       = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  bg_pix,
  input  logic [PIX_W-1:0]  spr0_pix,
  input  logic              spr0_valid,
  input  logic              bg_on,
  input  logic              spr_on,
  input  logic              bg_left_hide,
  input  logic              spr_left_hide,
  input  logic              nmi_en,
  input  logic              rd_stb,
  output logic [COL_W-1:0]  dot_col,
  output logic [LINE_W-1:0] scan_line,
  output logic [STAT_W-1:0] status_byte,
  output logic              nmi_req
);
  logic        visible_line, vbl_start, vbl_stop, hit_evt;
  render_ctl_t ctl;

  assign ctl = '{bg_on: bg_on, spr_on: spr_on,
                 bg_left_hide: bg_left_hide, spr_left_hide: spr_left_hide};

  sz_frame_timer #(
    .DOTS_PER_LINE(DOTS_PER_LINE), .VIS_LINES(VIS_LINES), .VBL_LINES(VBL_LINES),
    .TOTAL_LINES(TOTAL_LINES), .COL_W(COL_W), .LINE_W(LINE_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .col_o(dot_col), .line_o(scan_line),
    .visible_line_o(visible_line), .vbl_start_o(vbl_start), .vbl_stop_o(vbl_stop)
  );

  sz_hit_qualify #(
    .COL_W(COL_W), .VIS_COLS(VIS_COLS), .CLIP_COLS(CLIP_COLS)
  ) u_qual (
    .col_i(dot_col), .visible_line_i(visible_line), .bg_pix_i(bg_pix),
    .spr_pix_i(spr0_pix), .spr_valid_i(spr0_valid), .ctl_i(ctl), .hit_evt_o(hit_evt)
  );

  sz_status_regs u_stat (
    .clk(clk), .rst_n(rst_n), .hit_evt_i(hit_evt), .vbl_start_i(vbl_start),
    .vbl_stop_i(vbl_stop), .rd_stb_i(rd_stb), .nmi_en_i(nmi_en),
    .status_o(status_byte), .nmi_o(nmi_req)
  );

  // R3: the last pixel column never starts a hit
  assert_no_last_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_col == COL_W'(VIS_COLS - 1) && !status_byte[STAT_HIT_BIT]) |=> !status_byte[STAT_HIT_BIT]);
  // R2: a new hit needs both layers opaque on the previous dot
  assert_opaque_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_byte[STAT_HIT_BIT]) |-> $past((|bg_pix) && (|spr0_pix) && spr0_valid));
  // R4: a disabled layer blocks a new hit
  assert_layers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bg_on || !spr_on) && !status_byte[STAT_HIT_BIT]) |=> !status_byte[STAT_HIT_BIT]);
  // R12: unused status bits stay low
  assert_spare_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[STAT_W-3:0] == '0));
endmodule

// File: tb/sprite_zero_status_tb.sv
`timescale 1ns/1ps
module sprite_zero_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bg_pix, spr0_pix;
  logic       spr0_valid, bg_on, spr_on, bg_left_hide, spr_left_hide, nmi_en, rd_stb;
  logic [8:0] dot_col, scan_line;
  logic [7:0] status_byte;
  logic       nmi_req;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sprite_zero_status u_dut (
    .clk(clk), .rst_n(rst_n), .bg_pix(bg_pix), .spr0_pix(spr0_pix),
    .spr0_valid(spr0_valid), .bg_on(bg_on), .spr_on(spr_on),
    .bg_left_hide(bg_left_hide), .spr_left_hide(spr_left_hide), .nmi_en(nmi_en),
    .rd_stb(rd_stb), .dot_col(dot_col), .scan_line(scan_line),
    .status_byte(status_byte), .nmi_req(nmi_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    bg_pix = 2'd0; spr0_pix = 2'd0; spr0_valid = 1'b0;
    bg_on = 1'b1; spr_on = 1'b1; bg_left_hide = 1'b0; spr_left_hide = 1'b0;
    rd_stb = 1'b0;
  endtask

  task automatic go_to(input int ln, input int cl);
    while (!(int'(scan_line) == ln && int'(dot_col) == cl)) @(negedge clk);
  endtask

  task automatic try_px(input string req, input int ln, input int cl,
                        input logic [1:0] b, input logic [1:0] s, input logic v,
                        input logic bon, input logic son, input logic hb, input logic hs,
                        input int exp_stat);
    go_to(ln, cl);
    bg_pix = b; spr0_pix = s; spr0_valid = v;
    bg_on = bon; spr_on = son; bg_left_hide = hb; spr_left_hide = hs;
    @(negedge clk);
    idle();
    chk(req, status_byte, exp_stat);
  endtask

  task automatic t_reset();
    idle(); nmi_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset col", dot_col, 0);
    chk("R1 reset line", scan_line, 0);
    chk("R12 reset status", status_byte, 0);
    chk("R9 reset nmi", nmi_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first step", dot_col, 1);
    go_to(0, 340);
    @(negedge clk);
    chk("R1 line wrap col", dot_col, 0);
    chk("R1 line wrap line", scan_line, 1);
  endtask

  task automatic t_suppress();
    try_px("R3 col 255",            2, 255, 2'd1, 2'd1, 1'b1, 1, 1, 0, 0, 0);
    try_px("R4 bg off",             3, 100, 2'd1, 2'd1, 1'b1, 0, 1, 0, 0, 0);
    try_px("R4 spr off",            4, 100, 2'd3, 2'd3, 1'b1, 1, 0, 0, 0, 0);
    try_px("R5 bg left hide",       5,   3, 2'd1, 2'd2, 1'b1, 1, 1, 1, 0, 0);
    try_px("R5 spr left hide",      6,   7, 2'd1, 2'd2, 1'b1, 1, 1, 0, 1, 0);
    try_px("R2 bg transparent",     7, 100, 2'd0, 2'd3, 1'b1, 1, 1, 0, 0, 0);
    try_px("R2 spr invalid",        8, 100, 2'd2, 2'd3, 1'b0, 1, 1, 0, 0, 0);
    try_px("R6 dot past pixels",    9, 300, 2'd1, 2'd1, 1'b1, 1, 1, 0, 0, 0);
    try_px("R6 idle line",        240,  50, 2'd1, 2'd1, 1'b1, 1, 1, 0, 0, 0);
  endtask

  task automatic t_vblank_read();
    go_to(240, 340);
    chk("R8 before blank", status_byte, 0);
    @(negedge clk);
    chk("R8 start dot not yet visible", status_byte, 0);
    @(negedge clk);
    chk("R8 flag up", status_byte, 8'h80);
    chk("R9 nmi masked", nmi_req, 0);
    go_to(245, 0);
    rd_stb = 1'b1;
    chk("R10 read value", status_byte, 8'h80);
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R10 read cleared", status_byte, 0);
    go_to(261, 340);
    @(negedge clk);
    chk("R1 frame wrap line", scan_line, 0);
    chk("R1 frame wrap col", dot_col, 0);
  endtask

  task automatic t_hit();
    nmi_en = 1'b1;
    go_to(5, 254);
    bg_pix = 2'd1; spr0_pix = 2'd2; spr0_valid = 1'b1;
    bg_left_hide = 1'b1; spr_left_hide = 1'b1; rd_stb = 1'b1;
    chk("R10 read same dot as hit", status_byte, 0);
    @(negedge clk);
    idle();
    chk("R2 hit 1 with 2 at col 254", status_byte, 8'h40);
    go_to(20, 0);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R7 read keeps hit", status_byte, 8'h40);
    try_px("R7 later pixel", 200, 100, 2'd0, 2'd0, 1'b0, 1, 1, 0, 0, 8'h40);
  endtask

  task automatic t_blank_clear();
    go_to(241, 1);
    chk("R8 flag with hit", status_byte, 8'hC0);
    chk("R9 nmi pulse", nmi_req, 1);
    @(negedge clk);
    chk("R9 nmi one cycle", nmi_req, 0);
    go_to(261, 0);
    chk("R11 flags held to stop dot", status_byte, 8'hC0);
    @(negedge clk);
    chk("R11 flags cleared", status_byte, 0);
  endtask

  initial begin
    t_reset();
    t_suppress();
    t_vblank_read();
    t_hit();
    t_blank_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule